// File: doc/BRIEF.md
# Scanline Sprite Evaluator

Before each display line is drawn, this block walks a sprite attribute table of 128 entries and picks the sprites whose vertical extent covers that line. Each entry is one 32-bit word that holds four bytes. A single `line_start` pulse latches the target line number and the height mode (8x8 or 8x16). The block then reads the table one word per clock, from index 0 upward, through a read port with one cycle of latency.

Each accepted sprite fills the next free output slot. A slot holds the character index to fetch, the row inside that character, the unchanged X coordinate and the decoded attribute flags. Vertical flip and the tall mode's second character are already resolved in the slot. At most 16 sprites are kept per line. When a seventeenth sprite hits the line, the overflow flag is raised and the scan ends early. The slot list holds steady from `eval_done` until the next `line_start`, so the pixel pipeline can consume it during the following line.

Top module: `sprite_line_eval`

## Requirements
- R1: After reset, `eval_busy`, `eval_done`, `sat_rd_en`, `line_overflow`, `slot_count` and every `slot_valid` bit are 0.
- R2: A table word is split as follows: bits [7:0] are the character index, [15:8] the attribute byte, [23:16] the X coordinate and [31:24] the Y coordinate. The X of an accepted sprite appears unchanged in its slot.
- R3: In 8x8 mode (`tall_mode`=0), a sprite with top Y is accepted on line L only when 0 <= L-Y <= 7, computed without wrap. A sprite whose top lies below L is rejected, and so is one that would reach L only by wrapping past 255.
- R4: In 8x16 mode (`tall_mode`=1), the accepted span is 0 <= L-Y <= 15. Rows 8..15 use character index + 1, modulo 256. The slot row is (L-Y) mod 8.
- R5: Attribute bit 6 set means vertical flip. The effective row is 7-(L-Y) in 8x8 mode and 15-(L-Y) in 8x16 mode, so the upper and lower characters swap in tall mode.
- R6: A slot's 5-bit flag field is {attr[5] horizontal flip, attr[4] palette shift, attr[3] palette select, attr[2] priority, attr[1] scale}. Attribute bits 7 and 0 have no effect on any output.
- R7: Accepted sprites fill slots 0, 1, 2 ... in ascending table index, so a lower slot always means higher priority. `slot_count` equals the number of accepted sprites.
- R8: At most 16 slots are filled. On the seventeenth in-range sprite, `line_overflow` goes to 1. While it is 1, no further table read is issued. Exactly 16 hits leave it at 0.
- R9: Without overflow, all 128 entries are read once each, at addresses 0..127 in order. `eval_done` pulses for one cycle no more than 140 clocks after the `line_start` edge.
- R10: A `line_start` clears all slots, `slot_count` and `line_overflow` before the new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start evaluation for `line_num` |
| line_num | input | 8 | Line to be drawn next |
| tall_mode | input | 1 | 0: 8x8 sprites, 1: 8x16 sprites |
| sat_rd_en | output | 1 | Table read request |
| sat_rd_addr | output | 7 | Table entry index |
| sat_rd_data | input | 32 | Entry word, valid one cycle after the request |
| eval_busy | output | 1 | Scan in progress |
| eval_done | output | 1 | One-cycle pulse at the end of a scan |
| slot_valid | output | 16 | One bit per filled slot |
| slot_char | output | 128 | Character index per slot, 8 bits each |
| slot_row | output | 48 | Row in character per slot, 3 bits each |
| slot_x | output | 128 | X coordinate per slot, 8 bits each |
| slot_flags | output | 80 | Decoded flags per slot, 5 bits each |
| slot_count | output | 5 | Number of filled slots |
| line_overflow | output | 1 | More than 16 sprites hit the line |

## Verification
The bench targets the edges of the vertical window, and each has a clear failure signature.
- Window edges: it uses the last row of a sprite, the first row past it, a top below the line and a top near 255. An off-by-one compare or a modular subtraction would accept one of these.
- Tall mode and flip: it checks both halves with and without flip, plus character 255, where the lower half wraps to 0. A design that flips only the row bits or forgets the character increment fetches the wrong row.
- Slot limit: it runs exactly 16 hits and then 20 hits spread over the table. A wrong limit compare either raises overflow too early or overwrites slot 15. A design that keeps reading after overflow shows up as reads issued while the flag is set.
- Restart: a following line with no hits must show no stale slots.

// File: rtl/sprite_eval_pkg.sv
package sprite_eval_pkg;

    localparam int BYTE_W    = 8;
    localparam int ROW_W     = 3;
    localparam int FLAG_W    = 5;

    // Byte lanes of a table word
    localparam int CHAR_LSB  = 0;
    localparam int ATTR_LSB  = 8;
    localparam int XPOS_LSB  = 16;
    localparam int YPOS_LSB  = 24;

    // Attribute bit positions
    localparam int VFLIP_BIT = 6;
    localparam int HFLIP_BIT = 5;
    localparam int SHIFT_BIT = 4;
    localparam int PAL_BIT   = 3;
    localparam int PRIO_BIT  = 2;
    localparam int SCALE_BIT = 1;

    typedef struct packed {
        logic [BYTE_W-1:0] chr;
        logic [ROW_W-1:0]  row;
        logic [BYTE_W-1:0] xpos;
        logic [FLAG_W-1:0] flags;
    } slot_t;

endpackage

// File: rtl/sprite_row_match.sv
module sprite_row_match
    import sprite_eval_pkg::*;
(
    input  logic [7:0]  line_num,
    input  logic        tall_mode,
    input  logic [31:0] entry,
    output logic        hit,
    output slot_t       slot
);

    logic [8:0] diff;
    logic [3:0] rel_row;
    logic [3:0] eff_row;
    logic [7:0] top_y;
    logic [7:0] attr;

    always_comb begin
        top_y   = entry[YPOS_LSB +: BYTE_W];
        attr    = entry[ATTR_LSB +: BYTE_W];
        diff    = {1'b0, line_num} - {1'b0, top_y};
        // Non-negative and below the sprite height; no wrap
        hit     = !diff[8] && (diff[7:4] == 4'd0) && (tall_mode || !diff[3]);
        rel_row = diff[3:0];
        if (attr[VFLIP_BIT]) begin
            eff_row = {tall_mode & ~rel_row[3], ~rel_row[2:0]};
        end else begin
            eff_row = rel_row;
        end
        slot.chr   = entry[CHAR_LSB +: BYTE_W] + {7'd0, eff_row[3]};
        slot.row   = eff_row[2:0];
        slot.xpos  = entry[XPOS_LSB +: BYTE_W];
        slot.flags = {attr[HFLIP_BIT], attr[SHIFT_BIT], attr[PAL_BIT],
                      attr[PRIO_BIT], attr[SCALE_BIT]};
    end

endmodule

// File: rtl/sprite_scan_ctrl.sv
module sprite_scan_ctrl #(
    parameter int NUM_SPRITES = 128,
    parameter int IDX_W       = $clog2(NUM_SPRITES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic [7:0]       line_num,
    input  logic             tall_mode,
    input  logic             stop,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_addr,
    output logic             pend,
    output logic [7:0]       cur_line,
    output logic             cur_tall,
    output logic             busy,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SPRITES - 1);

    typedef struct packed {
        logic             issuing;
        logic             pend;
        logic             pend_last;
        logic [IDX_W-1:0] idx;
        logic [7:0]       line;
        logic             tall;
        logic             done;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  issue;

    always_comb begin
        issue          = st_q.issuing && !stop;
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.pend      = issue;
        st_d.pend_last = issue && (st_q.idx == LAST_IDX);
        if (issue) begin
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == LAST_IDX) begin
                st_d.issuing = 1'b0;
            end
        end
        if (stop && (st_q.issuing || st_q.pend)) begin
            st_d.issuing   = 1'b0;
            st_d.pend      = 1'b0;
            st_d.pend_last = 1'b0;
            st_d.done      = 1'b1;
        end else if (st_q.pend && st_q.pend_last) begin
            st_d.done = 1'b1;
        end
        if (line_start) begin
            st_d.issuing   = 1'b1;
            st_d.pend      = 1'b0;
            st_d.pend_last = 1'b0;
            st_d.idx       = '0;
            st_d.line      = line_num;
            st_d.tall      = tall_mode;
            st_d.done      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en    = issue;
    assign rd_addr  = st_q.idx;
    assign pend     = st_q.pend;
    assign cur_line = st_q.line;
    assign cur_tall = st_q.tall;
    assign busy     = st_q.issuing || st_q.pend;
    assign done     = st_q.done;

    // R9: successive reads step one entry at a time
    assert_reads_ascend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && !$past(line_start)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sprite_slot_bank.sv
module sprite_slot_bank
    import sprite_eval_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 wr_en,
    input  slot_t                wr_slot,
    output slot_t [NUM_SLOTS-1:0] slots,
    output logic [NUM_SLOTS-1:0] valid,
    output logic [CNT_W-1:0]     count,
    output logic                 overflow
);

    typedef struct packed {
        slot_t [NUM_SLOTS-1:0] slots;
        logic [NUM_SLOTS-1:0]  valid;
        logic [CNT_W-1:0]      count;
        logic                  ovf;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (clear) begin
            bk_d = '0;
        end else if (wr_en && !bk_q.ovf) begin
            if (bk_q.count < CNT_W'(NUM_SLOTS)) begin
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    if (bk_q.count == CNT_W'(i)) begin
                        bk_d.slots[i] = wr_slot;
                        bk_d.valid[i] = 1'b1;
                    end
                end
                bk_d.count = bk_q.count + 1'b1;
            end else begin
                bk_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign slots    = bk_q.slots;
    assign valid    = bk_q.valid;
    assign count    = bk_q.count;
    assign overflow = bk_q.ovf;

    // R8: overflow only once every slot is taken
    assert_overflow_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (count == CNT_W'(NUM_SLOTS)));

    // R10: a new line empties the list
    assert_clear_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (valid == '0 && count == '0 && !overflow));

    // R7: the count only shrinks through a clear
    assert_count_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count < $past(count)) |-> $past(clear));

endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
    import sprite_eval_pkg::*;
#(
    parameter int NUM_SPRITES = 128,
    parameter int NUM_SLOTS   = 16,
    localparam int IDX_W      = $clog2(NUM_SPRITES),
    localparam int CNT_W      = $clog2(NUM_SLOTS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_start,
    input  logic [7:0]                    line_num,
    input  logic                          tall_mode,
    output logic                          sat_rd_en,
    output logic [IDX_W-1:0]              sat_rd_addr,
    input  logic [31:0]                   sat_rd_data,
    output logic                          eval_busy,
    output logic                          eval_done,
    output logic [NUM_SLOTS-1:0]          slot_valid,
    output logic [NUM_SLOTS*BYTE_W-1:0]   slot_char,
    output logic [NUM_SLOTS*ROW_W-1:0]    slot_row,
    output logic [NUM_SLOTS*BYTE_W-1:0]   slot_x,
    output logic [NUM_SLOTS*FLAG_W-1:0]   slot_flags,
    output logic [CNT_W-1:0]              slot_count,
    output logic                          line_overflow
);

    logic                  pend;
    logic [7:0]            cur_line;
    logic                  cur_tall;
    logic                  hit;
    slot_t                 hit_slot;
    slot_t [NUM_SLOTS-1:0] slots;

    sprite_scan_ctrl #(
        .NUM_SPRITES (NUM_SPRITES),
        .IDX_W       (IDX_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .line_num   (line_num),
        .tall_mode  (tall_mode),
        .stop       (line_overflow),
        .rd_en      (sat_rd_en),
        .rd_addr    (sat_rd_addr),
        .pend       (pend),
        .cur_line   (cur_line),
        .cur_tall   (cur_tall),
        .busy       (eval_busy),
        .done       (eval_done)
    );

    sprite_row_match match_i (
        .line_num  (cur_line),
        .tall_mode (cur_tall),
        .entry     (sat_rd_data),
        .hit       (hit),
        .slot      (hit_slot)
    );

    sprite_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (line_start),
        .wr_en    (pend && hit),
        .wr_slot  (hit_slot),
        .slots    (slots),
        .valid    (slot_valid),
        .count    (slot_count),
        .overflow (line_overflow)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flat
        assign slot_char[g*BYTE_W +: BYTE_W]  = slots[g].chr;
        assign slot_row[g*ROW_W +: ROW_W]     = slots[g].row;
        assign slot_x[g*BYTE_W +: BYTE_W]     = slots[g].xpos;
        assign slot_flags[g*FLAG_W +: FLAG_W] = slots[g].flags;
    end

    // R8: no table traffic once the line has overflowed
    assert_no_read_after_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_overflow |-> !sat_rd_en);

endmodule

// File: tb/sprite_line_eval_tb_top.sv
module sprite_line_eval_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_start = 1'b0;
    logic [7:0]   line_num = '0;
    logic         tall_mode = 1'b0;
    logic         sat_rd_en;
    logic [6:0]   sat_rd_addr;
    logic [31:0]  sat_rd_data = '0;
    logic         eval_busy;
    logic         eval_done;
    logic [15:0]  slot_valid;
    logic [127:0] slot_char;
    logic [47:0]  slot_row;
    logic [127:0] slot_x;
    logic [79:0]  slot_flags;
    logic [4:0]   slot_count;
    logic         line_overflow;

    logic [31:0]  sat_mem [128];
    int           total = 0;
    int           fails = 0;
    int           cycles = 0;
    int           rd_count = 0;
    int           exp_addr = 0;
    int           addr_err = 0;
    int           ovf_rd = 0;

    always #10 clk = ~clk;

    sprite_line_eval dut_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
        .tall_mode(tall_mode), .sat_rd_en(sat_rd_en), .sat_rd_addr(sat_rd_addr),
        .sat_rd_data(sat_rd_data), .eval_busy(eval_busy), .eval_done(eval_done),
        .slot_valid(slot_valid), .slot_char(slot_char), .slot_row(slot_row),
        .slot_x(slot_x), .slot_flags(slot_flags), .slot_count(slot_count),
        .line_overflow(line_overflow)
    );

    always @(posedge clk) begin
        if (sat_rd_en) sat_rd_data <= sat_mem[sat_rd_addr];
    end

    always @(negedge clk) begin
        if (sat_rd_en) begin
            if (sat_rd_addr != exp_addr[6:0]) addr_err++;
            exp_addr++;
            rd_count++;
        end
        if (line_overflow && sat_rd_en) ovf_rd++;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] ch, input logic [7:0] at,
                                       input logic [7:0] x, input logic [7:0] y);
        return {y, x, at, ch};
    endfunction

    task automatic clear_table();
        for (int i = 0; i < 128; i++) sat_mem[i] = mk(8'h00, 8'h00, 8'h00, 8'd240);
    endtask

    task automatic run_line(input int ln, input bit tall);
        int n;
        @(negedge clk);
        line_num = ln[7:0];
        tall_mode = tall;
        line_start = 1'b1;
        rd_count = 0;
        exp_addr = 0;
        addr_err = 0;
        ovf_rd = 0;
        @(negedge clk);
        line_start = 1'b0;
        n = 1;
        while (!eval_done && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk("R9 done seen", {31'd0, eval_done}, 32'd1);
        chk("R9 done latency within 140", {31'd0, n <= 140}, 32'd1);
        @(negedge clk);
        chk("R9 done single pulse", {31'd0, eval_done}, 32'd0);
        chk("R8 no read during overflow", ovf_rd, 0);
        chk("R9 read order", addr_err, 0);
    endtask

    // Reference from the requirements: compare every slot
    task automatic compare_model(input int ln, input bit tall, input string tag);
        int cnt = 0;
        bit ovf = 0;
        int h = tall ? 16 : 8;
        for (int s = 0; s < 128; s++) begin
            int y = int'(sat_mem[s][31:24]);
            logic [7:0] at = sat_mem[s][15:8];
            if (!ovf && ln >= y && ln - y < h) begin
                if (cnt < 16) begin
                    int r = ln - y;
                    logic [7:0] ch;
                    if (at[6]) r = h - 1 - r;
                    ch = sat_mem[s][7:0] + ((r >= 8) ? 8'd1 : 8'd0);
                    chk({tag, " R4 char"}, {24'd0, slot_char[cnt*8 +: 8]}, {24'd0, ch});
                    chk({tag, " R5 row"}, {29'd0, slot_row[cnt*3 +: 3]}, r % 8);
                    chk({tag, " R2 x"}, {24'd0, slot_x[cnt*8 +: 8]}, {24'd0, sat_mem[s][23:16]});
                    chk({tag, " R6 flags"}, {27'd0, slot_flags[cnt*5 +: 5]}, {27'd0, at[5:1]});
                    cnt++;
                end else begin
                    ovf = 1;
                end
            end
        end
        chk({tag, " R7 count"}, {27'd0, slot_count}, cnt);
        chk({tag, " R7 valid"}, {16'd0, slot_valid}, (32'd1 << cnt) - 1);
        chk({tag, " R8 overflow"}, {31'd0, line_overflow}, {31'd0, ovf});
    endtask

    task automatic t_reset();
        chk("R1 busy", {31'd0, eval_busy}, 0);
        chk("R1 done", {31'd0, eval_done}, 0);
        chk("R1 rd_en", {31'd0, sat_rd_en}, 0);
        chk("R1 overflow", {31'd0, line_overflow}, 0);
        chk("R1 count", {27'd0, slot_count}, 0);
        chk("R1 valid", {16'd0, slot_valid}, 0);
    endtask

    task automatic t_basic();
        clear_table();
        sat_mem[5]  = mk(8'h40, 8'hA9, 8'd33, 8'd10);
        sat_mem[9]  = mk(8'h51, 8'h00, 8'd70, 8'd13);
        sat_mem[3]  = mk(8'h22, 8'h00, 8'd90, 8'd4);
        sat_mem[11] = mk(8'h33, 8'h00, 8'd5, 8'd250);
        run_line(12, 0);
        chk("R3 only one in window", {27'd0, slot_count}, 1);
        chk("R2 char", {24'd0, slot_char[7:0]}, 32'h40);
        chk("R2 row", {29'd0, slot_row[2:0]}, 2);
        chk("R2 x", {24'd0, slot_x[7:0]}, 33);
        chk("R6 flags", {27'd0, slot_flags[4:0]}, 32'b10100);
        sat_mem[5] = mk(8'h40, 8'h28, 8'd33, 8'd10);
        run_line(12, 0);
        chk("R6 bits 7 and 0 ignored flags", {27'd0, slot_flags[4:0]}, 32'b10100);
        chk("R6 bits 7 and 0 ignored row", {29'd0, slot_row[2:0]}, 2);
        run_line(2, 0);
        chk("R3 no wrap from 250", {27'd0, slot_count}, 0);
        run_line(17, 0);
        compare_model(17, 0, "R3 last row");
        run_line(18, 0);
        compare_model(18, 0, "R3 past last row");
    endtask

    task automatic t_flip_tall();
        clear_table();
        sat_mem[5] = mk(8'h40, 8'h40, 8'd33, 8'd10);
        sat_mem[6] = mk(8'hFF, 8'h00, 8'd44, 8'd10);
        sat_mem[7] = mk(8'hFF, 8'h40, 8'd55, 8'd10);
        run_line(12, 0);
        chk("R5 vflip 8x8 row", {29'd0, slot_row[2:0]}, 5);
        run_line(20, 1);
        chk("R5 vflip tall char", {24'd0, slot_char[7:0]}, 32'h40);
        chk("R5 vflip tall row", {29'd0, slot_row[2:0]}, 5);
        chk("R4 lower half wraps char", {24'd0, slot_char[15:8]}, 32'h00);
        chk("R4 lower half row", {29'd0, slot_row[5:3]}, 2);
        chk("R5 vflip tall upper", {24'd0, slot_char[23:16]}, 32'hFF);
        compare_model(20, 1, "R4 tall mid");
        run_line(25, 1);
        compare_model(25, 1, "R4 tall last row");
        run_line(26, 1);
        chk("R4 tall past end", {27'd0, slot_count}, 0);
    endtask

    task automatic t_order();
        clear_table();
        sat_mem[100] = mk(8'h01, 8'h00, 8'd100, 8'd60);
        sat_mem[7]   = mk(8'h02, 8'h00, 8'd7, 8'd60);
        sat_mem[50]  = mk(8'h03, 8'h00, 8'd50, 8'd60);
        run_line(62, 0);
        chk("R7 slot0 lowest index", {24'd0, slot_x[7:0]}, 7);
        chk("R7 slot1", {24'd0, slot_x[15:8]}, 50);
        chk("R7 slot2", {24'd0, slot_x[23:16]}, 100);
        chk("R7 count", {27'd0, slot_count}, 3);
        chk("R9 full scan reads", rd_count, 128);
    endtask

    task automatic t_limit();
        clear_table();
        for (int k = 0; k < 16; k++) sat_mem[k * 7] = mk(8'(k), 8'h00, 8'(k * 7), 8'd100);
        run_line(103, 0);
        chk("R8 exactly 16 no overflow", {31'd0, line_overflow}, 0);
        chk("R8 exactly 16 count", {27'd0, slot_count}, 16);
        clear_table();
        for (int k = 0; k < 20; k++) sat_mem[k * 2] = mk(8'(k), 8'h00, 8'(k * 2), 8'd100);
        run_line(103, 0);
        chk("R8 overflow raised", {31'd0, line_overflow}, 1);
        chk("R8 count capped", {27'd0, slot_count}, 16);
        chk("R8 slot15 keeps 16th", {24'd0, slot_x[127:120]}, 30);
        chk("R8 scan stopped early", {31'd0, rd_count < 40}, 1);
        compare_model(103, 0, "R8 overflow");
    endtask

    task automatic t_restart();
        clear_table();
        run_line(103, 0);
        chk("R10 overflow cleared", {31'd0, line_overflow}, 0);
        chk("R10 slots cleared", {16'd0, slot_valid}, 0);
        chk("R10 count cleared", {27'd0, slot_count}, 0);
        chk("R9 all entries read", rd_count, 128);
    endtask

    initial begin
        clear_table();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_flip_tall();
        t_order();
        t_limit();
        t_restart();
        summary();
        $finish;
    end

endmodule